// File: doc/BRIEF.md
# Seeded Radix-16 Integer Square Root

This block returns the floor square root of an unsigned radicand. A request is a one-cycle `start_i` pulse that presents the radicand. After a short, data-dependent number of cycles, `done_o` pulses and `root_o` carries the result. `root_o` keeps that result until the next request is accepted. While `busy_o` is high the block works on its captured radicand, and any further `start_i` is dropped.

The block fills the root in from the top down. First, a seed stage derives the eight most significant root bits from the top sixteen radicand bits. This stage is a computed lookup of the integer square root of that 16-bit slice. After that, each iteration appends all sixteen possible 4-bit digits to the partial root and squares every candidate in parallel. Each square is compared against the radicand after the radicand has been scaled to the candidate's weight. A comparator tree keeps the largest candidate whose square does not exceed the scaled radicand. With the default widths, six iterations reach the least significant root bit.

The loop stops as soon as the chosen partial root, padded with zeros, squares exactly to the radicand. This early exit makes the latency depend on the data.

Top module: `isqrt_r16`

## Requirements
- R1: For every radicand X, the root delivered with `done_o` is the largest integer r with r*r <= X. With the default widths, X is 64 bits and r is 32 bits.
- R2: Root bits [31:24] equal the floor square root of radicand bits [63:48].
- R3: Count the clock edge that samples an accepted `start_i` as edge 1. For a nonzero radicand whose root is not exact, `done_o` is high after edge 8.
- R4: For a nonzero radicand with an exact root r, `done_o` is high after edge 2+j. Here j is the smallest value in 1..6 for which r is a multiple of 2^(4*(6-j)). A root whose low 24 bits are zero therefore finishes after edge 3.
- R5: A zero radicand gives root 0, with `done_o` high after edge 2.
- R6: `busy_o` rises after the accepting edge and stays high until the edge that raises `done_o`, where it falls. `done_o` is high for exactly one cycle.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. The running result and its timing are unchanged.
- R8: `root_o` changes only on the edge that raises `done_o`. Between requests it holds its value, whatever `radicand_i` does.
- R9: After reset, `busy_o` and `done_o` are low and `root_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse; accepted only when not busy |
| radicand_i | input | RAD_W (64) | Value to take the root of, captured on acceptance |
| busy_o | output | 1 | High while a request is being worked on |
| done_o | output | 1 | One-cycle pulse when the root is valid |
| root_o | output | ROOT_W (32) | Floor square root of the last accepted radicand |

## Verification
Each result has a fixed due time once the radicand is known. The due edge is 2 for zero, 2+j for an exact root that resolves at iteration j, and 8 otherwise, counting the accepting edge as 1. The bench drives on the falling edge and counts rising edges until `done_o` appears. It compares that count with the edge computed from its own reference square root. It checks the root in the same cycle, then confirms one cycle later that `done_o` has dropped. For requests made while busy, and for the hold period between requests, the bench reads `root_o` and the done timing directly at the ports.

// File: rtl/isqrt_r16_pkg.sv
// Shared types for the radix-16 square root.
// Assumes nothing beyond the sequencer using the state type below.
package isqrt_r16_pkg;

    // Sequencer states: waiting, seeding the top root bits, resolving digits.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_ITER = 2'd2
    } sq_state_e;

endpackage

// File: rtl/isqrt_r16_seed.sv
// Seed stage: floor square root of the top 2*SEED_W radicand bits.
// This gives the top SEED_W root bits exactly. The lookup is computed as
// a thermometer of threshold compares against s*s and needs no stored table.
// Assumes RAD_W >= 2*SEED_W.
module isqrt_r16_seed #(
    parameter int RAD_W  = 64,
    parameter int SEED_W = 8
) (
    input  logic [RAD_W-1:0]  rad_i,
    output logic [SEED_W-1:0] seed_o
);
    localparam int IDX_W = 2 * SEED_W;
    localparam int SEEDS = 1 << SEED_W;

    logic [IDX_W-1:0]   idx;
    logic [SEEDS-1:1]   ge;
    logic [SEED_W:0]    cnt;

    assign idx = rad_i[RAD_W-1 -: IDX_W];

    // One threshold compare per nonzero seed value.
    for (genvar s = 1; s < SEEDS; s++) begin : g_thr
        assign ge[s] = (idx >= IDX_W'(s * s));
    end

    // Count the thresholds passed; that count is the floor root.
    always_comb begin
        cnt = '0;
        for (int s = 1; s < SEEDS; s++) begin
            cnt = cnt + (SEED_W + 1)'(ge[s]);
        end
    end

    assign seed_o = cnt[SEED_W-1:0];

endmodule

// File: rtl/isqrt_r16_cand.sv
// Candidate squarers: form every extension of the partial root by one
// STEP_W-bit digit, square each one, and flag those whose square is not
// above the scaled radicand limit.
// Assumes part_i uses only its low ROOT_W-STEP_W bits.
module isqrt_r16_cand #(
    parameter int RAD_W  = 64,
    parameter int ROOT_W = 32,
    parameter int STEP_W = 4
) (
    input  logic [ROOT_W-1:0]        part_i,
    input  logic [RAD_W-1:0]         lim_i,
    output logic [(1<<STEP_W)-1:0]   ok_o
);
    localparam int N = 1 << STEP_W;

    for (genvar d = 0; d < N; d++) begin : g_cand
        logic [ROOT_W-1:0] cand;
        logic [RAD_W-1:0]  sq;
        // Append digit d, square, compare against the limit.
        assign cand    = (part_i << STEP_W) | ROOT_W'(d);
        assign sq      = RAD_W'(cand) * RAD_W'(cand);
        assign ok_o[d] = (sq <= lim_i);
    end

endmodule

// File: rtl/isqrt_r16_tree.sv
// Comparator tree: chooses the highest digit whose candidate is accepted.
// It is a binary heap of 2-input pickers; the higher-index side wins when valid.
// Assumes the accept flags come from candidates in increasing digit order.
module isqrt_r16_tree #(
    parameter int STEP_W = 4
) (
    input  logic [(1<<STEP_W)-1:0] ok_i,
    output logic [STEP_W-1:0]      pick_o,
    output logic                   any_o
);
    localparam int N     = 1 << STEP_W;
    localparam int NODES = 2 * N - 1;

    logic [NODES-1:0]  vld;
    logic [STEP_W-1:0] ix [NODES];

    // Leaves: one per digit.
    for (genvar d = 0; d < N; d++) begin : g_leaf
        assign vld[N-1+d] = ok_i[d];
        assign ix[N-1+d]  = STEP_W'(d);
    end

    // Internal nodes: prefer the right (higher digit) child when it is valid.
    for (genvar i = 0; i < N - 1; i++) begin : g_node
        assign vld[i] = vld[2*i+1] | vld[2*i+2];
        assign ix[i]  = vld[2*i+2] ? ix[2*i+2] : ix[2*i+1];
    end

    assign pick_o = ix[0];
    assign any_o  = vld[0];

endmodule

// File: rtl/isqrt_r16.sv
// Multicycle floor square root with a seeded top root byte and STEP_W-bit
// digits per iteration. It captures the radicand on start, seeds the top
// SEED_W root bits in one cycle, then resolves one digit per cycle. It
// stops early when the partial root, zero-padded, squares to the radicand.
// Assumes (ROOT_W-SEED_W) is a multiple of STEP_W and RAD_W == 2*ROOT_W.
module isqrt_r16 #(
    parameter int RAD_W  = 64,
    parameter int ROOT_W = 32,
    parameter int SEED_W = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RAD_W-1:0]  radicand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ROOT_W-1:0] root_o
);
    import isqrt_r16_pkg::*;

    localparam int ITERS = (ROOT_W - SEED_W) / STEP_W;
    localparam int IT_W  = $clog2(ITERS + 1);
    localparam int N     = 1 << STEP_W;

    sq_state_e         state_q;
    logic [RAD_W-1:0]  rad_q;
    logic [ROOT_W-1:0] part_q;
    logic [IT_W-1:0]   iter_q;
    logic              busy_q;
    logic              done_q;
    logic [ROOT_W-1:0] root_q;

    logic [SEED_W-1:0] seed;
    int                sh_int;
    logic [7:0]        shamt;
    logic [7:0]        shamt_prev;
    logic [RAD_W-1:0]  rad_sh;
    logic [N-1:0]      ok;
    logic [STEP_W-1:0] pick;
    logic              any_ok;
    logic [ROOT_W-1:0] best;
    logic [RAD_W-1:0]  best_sq;
    logic              low_zero;
    logic              exact;
    logic              last;

    // Seed lookup on the captured radicand.
    isqrt_r16_seed #(.RAD_W(RAD_W), .SEED_W(SEED_W)) seed_i (
        .rad_i  (rad_q),
        .seed_o (seed)
    );

    // Weight of the digit resolved this iteration, as a bit shift of the root.
    always_comb begin
        sh_int = STEP_W * (ITERS - 1 - int'(iter_q));
        if (sh_int < 0) sh_int = 0;
        shamt      = 8'(2 * sh_int);
        shamt_prev = 8'(2 * (sh_int + STEP_W));
    end

    assign rad_sh   = rad_q >> shamt;
    assign low_zero = ((rad_q & ~({RAD_W{1'b1}} << shamt)) == '0);

    // Parallel candidate squaring against the scaled radicand.
    isqrt_r16_cand #(.RAD_W(RAD_W), .ROOT_W(ROOT_W), .STEP_W(STEP_W)) cand_i (
        .part_i (part_q),
        .lim_i  (rad_sh),
        .ok_o   (ok)
    );

    // Largest accepted digit.
    isqrt_r16_tree #(.STEP_W(STEP_W)) tree_i (
        .ok_i   (ok),
        .pick_o (pick),
        .any_o  (any_ok)
    );

    assign best    = (part_q << STEP_W) | ROOT_W'(pick);
    assign best_sq = RAD_W'(best) * RAD_W'(best);
    assign exact   = (best_sq == rad_sh) && low_zero;
    assign last    = (iter_q == IT_W'(ITERS - 1));

    // Sequencer: accept, seed, iterate, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rad_q   <= '0;
            part_q  <= '0;
            iter_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            root_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rad_q   <= radicand_i;
                        busy_q  <= 1'b1;
                        state_q <= ST_SEED;
                    end
                end
                ST_SEED: begin
                    part_q <= ROOT_W'(seed);
                    iter_q <= '0;
                    if (rad_q == '0) begin
                        root_q  <= '0;
                        done_q  <= 1'b1;
                        busy_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    part_q <= best;
                    iter_q <= iter_q + 1'b1;
                    if (exact || last) begin
                        root_q  <= best << sh_int;
                        done_q  <= 1'b1;
                        busy_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign root_o = root_q;

    // R1: the partial root never overshoots the radicand at its own weight.
    a_r1_partial_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |->
            ((RAD_W'(part_q) * RAD_W'(part_q)) <= (rad_q >> shamt_prev)));

    // R1: the tree always finds an acceptable digit.
    a_r1_has_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> any_ok);

    // R5: a zero radicand finishes right after the seed stage with root 0.
    a_r5_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED && rad_q == '0) |=> (done_o && root_o == '0));

    // R6: done is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: busy falls exactly when done rises.
    a_r6_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R7: a start while busy neither ends nor restarts the run.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R8: the root only moves together with done.
    a_r8_root_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(root_o));

endmodule

// File: tb/isqrt_r16_tb_top.sv
`timescale 1ns/1ps
module isqrt_r16_tb_top;
    logic        clk;
    logic        rst_n;
    logic        start;
    logic [63:0] radicand;
    logic        busy;
    logic        done;
    logic [31:0] root;

    int checks;
    int errors;
    int cyc;

    isqrt_r16 dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .radicand_i (radicand),
        .busy_o     (busy),
        .done_o     (done),
        .root_o     (root)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic longint unsigned ref_isqrt(longint unsigned x);
        longint unsigned r = 0;
        for (int b = 31; b >= 0; b--) begin
            longint unsigned t = r | (64'd1 << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

    // Edge after which done is due, counting the accepting edge as 1.
    function automatic int due_edge(longint unsigned x);
        longint unsigned r;
        if (x == 0) return 2;
        r = ref_isqrt(x);
        if (r * r == x) begin
            for (int j = 1; j <= 6; j++) begin
                if ((r & ((64'd1 << (4 * (6 - j))) - 1)) == 0) return 2 + j;
            end
        end
        return 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request; optionally a second start while busy (R7).
    task automatic run(input logic [63:0] x, input bit intrude);
        int  edges;
        bit  busy_gap;
        longint unsigned er;
        string lreq;
        er = ref_isqrt(x);
        @(negedge clk);
        radicand = x;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start    = 1'b0;
        edges    = 1;
        busy_gap = 1'b0;
        while (!done && edges < 40) begin
            if (!busy) busy_gap = 1'b1;
            if (intrude && edges == 2) begin
                start    = 1'b1;
                radicand = ~x;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            edges = edges + 1;
        end
        if (x == 0) lreq = "R5";
        else if (er * er == x) lreq = "R4";
        else lreq = "R3";
        chk(root == 32'(er), intrude ? "R7" : "R1", "root", root, er);
        chk(root[31:24] == 8'(ref_isqrt(x >> 48)), "R2", "seed bits",
            root[31:24], ref_isqrt(x >> 48));
        chk(edges == due_edge(x), intrude ? "R7" : lreq, "done edge",
            edges, due_edge(x));
        chk(!busy_gap && !busy, "R6", "busy window", busy_gap, 0);
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R6", "done width", done, 0);
    endtask

    initial begin
        logic [63:0] s;
        logic [31:0] held;
        checks   = 0;
        errors   = 0;
        cyc      = 0;
        rst_n    = 1'b0;
        start    = 1'b0;
        radicand = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state.
        chk(!busy && !done && root == 0, "R9", "reset state",
            {busy, done, root}, 0);

        // R5: zero radicand.
        run(64'd0, 1'b0);

        // R1 corners.
        run(64'd1, 1'b0);
        run(64'd2, 1'b0);
        run(64'd3, 1'b0);
        run(64'd4, 1'b0);
        run(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run(64'hFFFF_FFFE_0000_0001, 1'b0);
        run(64'hFFFF_FFFE_0000_0000, 1'b0);
        run(64'h4000_0000_0000_0000, 1'b0);

        // R4: exact roots with trailing zero digits, and their neighbours (R1).
        for (int m = 0; m <= 6; m++) begin
            for (int k = 0; k < 4; k++) begin
                longint unsigned base;
                longint unsigned r;
                base = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 15 : 9;
                r = base << (4 * m);
                if (r < 64'h1_0000_0000) begin
                    run(r * r, 1'b0);
                    run(r * r + 1, 1'b0);
                    if (r > 1) run(r * r - 1, 1'b0);
                end
            end
        end

        // R2: every seed threshold in the top 16 bits, hit and just missed.
        for (int t = 1; t < 256; t++) begin
            run({16'(t * t), 48'h0000_1234_5678}, 1'b0);
            run({16'(t * t - 1), 48'hFFFF_FFFF_FFFF}, 1'b0);
        end

        // R1: pseudo-random radicands.
        s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 300; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            run(s >> (i % 40), 1'b0);
        end

        // R7: start while busy is ignored.
        run(64'h0123_4567_89AB_CDEF, 1'b1);
        run(64'h0000_0001_0000_0000, 1'b1);
        run(64'hFFFF_FFFE_0000_0001, 1'b1);

        // R8: root holds between requests while the radicand input moves.
        held = root;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            radicand = 64'(i) * 64'h1111_1111_1111_1111;
        end
        @(negedge clk);
        chk(root == held && !done, "R8", "root hold", root, held);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule